// File: doc/BRIEF.md
# Line Memory Capture Window Controller

This block stores one horizontal line of 9-bit sensor samples into an on-chip line delay memory so that a later stage can read the previous line back. A falling edge on the horizontal reference input starts a new line. It zeroes a sample position counter and arms a capture window. Every sample whose position lies between a programmable first position and a programmable last position is written to consecutive memory words, starting at word 0. The last position is honoured only to even resolution.

Two configuration bits pick the clock edge used for the incoming data and the clock edge used for the reference synchroniser. This lets the block meet the timing of sensors that launch on either edge. A line-type input is captured at the reference edge and says which complementary colour pair the line carries. Samples alternate between the two members of that pair. The readback port is a plain addressed port with one cycle of latency. With each word it returns a colour code derived from the stored line type and the parity of the sample position. When the window closes, the block gives a one-cycle done pulse and holds the number of stored samples on the count output.

Top module: `linecap_top`

## Requirements
- R1: While reset is held and after its release, and before any reference falling edge, `line_done_o` is 0 and `count_o` is 0.
- R2: With `data_rise_i`=1 a sample is the value `smp_i` holds at a rising clock edge. With `data_rise_i`=0 it is the value held at the preceding falling clock edge.
- R3: The reference input passes through two flops clocked on the rising edge (`ref_rise_i`=1) or the falling edge (`ref_rise_i`=0) before its falling edge is detected. Position 0 is the sample presented two clock cycles after the first cycle with `href_i` low in the rising case, and one cycle after it in the falling case.
- R4: A sample at position p is stored when start ≤ p ≤ stop with bit 0 of stop forced to 0. Start and stop are 14-bit values taken at the reference falling edge.
- R5: The first stored sample goes to memory word 0, and each further stored sample goes to the next word.
- R6: No more than 768 samples are stored per line, whatever the stop position.
- R7: The cycle after the window closes, `line_done_o` is high for exactly one clock. `count_o` then equals the number of stored samples and holds that value until the next reference falling edge. No sample is written once the window has closed.
- R8: `rd_colour_o` uses the codes 0=a, 1=b, 2=c, 3=d. Bit 1 is the inverse of `line_type_i` as captured at the reference falling edge. Bit 0 is bit 0 of (start + read address), so even positions give the first member of the pair.
- R9: `rd_data_o` and `rd_colour_o` reflect `rd_addr_i` one rising clock edge after it is applied.
- R10: When start is above the even-forced stop, nothing is stored, and the line still ends with a done pulse and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 9 | Sensor sample |
| href_i | input | 1 | Horizontal reference; its falling edge starts a line |
| line_type_i | input | 1 | Line type: 1 selects pair (a, b), 0 selects pair (c, d) |
| data_rise_i | input | 1 | Data latch edge: 1 rising, 0 falling |
| ref_rise_i | input | 1 | Reference synchroniser edge: 1 rising, 0 falling |
| start_i | input | 14 | First stored position |
| stop_i | input | 14 | Last stored position (bit 0 ignored) |
| rd_addr_i | input | 10 | Readback word address |
| rd_data_o | output | 9 | Readback sample |
| rd_colour_o | output | 2 | Colour code of the read sample |
| line_done_o | output | 1 | One-cycle pulse when the window closes |
| count_o | output | 10 | Number of samples stored in the current line |

## Verification
The properties assume that the edge selects, start and stop are changed only while the reference is high and settled. They also assume that a new reference falling edge does not arrive before the previous window has closed. The stimulus holds every line low until well past the closing position and holds the reference high for several cycles between lines. Configuration is updated only inside those high stretches. The sample input changes twice per clock, before and after the falling edge, so that the two data-edge settings store different values.

// File: rtl/linecap_pkg.sv
package linecap_pkg;
  localparam int unsigned SMP_W_DEF = 9;
  localparam int unsigned POS_W_DEF = 14;
  localparam int unsigned DEPTH_DEF = 768;

  typedef enum logic [1:0] {
    COL_A = 2'd0,
    COL_B = 2'd1,
    COL_C = 2'd2,
    COL_D = 2'd3
  } colour_e;
endpackage

// File: rtl/linecap_rst_sync.sv
module linecap_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1, s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end

  assign rst_no = s2;
endmodule

// File: rtl/linecap_front.sv
module linecap_front #(
  parameter int unsigned SMP_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_rise_i,
  input  logic             ref_rise_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             href_i,
  output logic [SMP_W-1:0] smp_o,
  output logic             ref_fall_o
);
  logic [SMP_W-1:0] smp_fe;
  logic [SMP_W-1:0] smp_q;
  logic             rp1, rp2, rn1, rn2;
  logic             ref_d;
  logic             ref_s;
  logic [SMP_W-1:0] smp_sel;

  // Falling-edge capture of the data
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_fe <= '0;
    else         smp_fe <= smp_i;
  end

  // Reference synchroniser, falling-edge flavour (idle high)
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rn1 <= 1'b1;
      rn2 <= 1'b1;
    end else begin
      rn1 <= href_i;
      rn2 <= rn1;
    end
  end

  // Reference synchroniser, rising-edge flavour (idle high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp1 <= 1'b1;
      rp2 <= 1'b1;
    end else begin
      rp1 <= href_i;
      rp2 <= rp1;
    end
  end

  always_comb begin
    smp_sel = data_rise_i ? smp_i : smp_fe;
    ref_s   = ref_rise_i ? rp2 : rn2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      ref_d <= 1'b1;
    end else begin
      smp_q <= smp_sel;
      ref_d <= ref_s;
    end
  end

  assign smp_o      = smp_q;
  assign ref_fall_o = ref_d & ~ref_s;
endmodule

// File: rtl/linecap_window.sv
module linecap_window #(
  parameter int unsigned POS_W = 14,
  parameter int unsigned DEPTH = 768,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned WA_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_fall_i,
  input  logic             line_type_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] stop_i,
  output logic             wr_en_o,
  output logic [WA_W-1:0]  wr_addr_o,
  output logic [POS_W-1:0] pos_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             line_type_o,
  output logic             start_lsb_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [POS_W-1:0] pos_q, pos_n;
  logic [POS_W-1:0] start_q, start_n, stop_q, stop_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             armed_q, armed_n;
  logic             done_q, done_n;
  logic             lt_q, lt_n;
  logic [POS_W-1:0] stop_e;
  logic             in_rng, full, wr_en, close;

  always_comb begin
    stop_e  = stop_q & ~POS_W'(1);
    in_rng  = (pos_q >= start_q) && (pos_q <= stop_e);
    full    = (cnt_q == CNT_FULL);
    wr_en   = armed_q && in_rng && !full && !ref_fall_i;
    close   = armed_q && ((pos_q > stop_e) || full);

    pos_n   = pos_q;
    start_n = start_q;
    stop_n  = stop_q;
    cnt_n   = cnt_q;
    armed_n = armed_q;
    lt_n    = lt_q;
    done_n  = 1'b0;

    if (ref_fall_i) begin
      pos_n   = '0;
      start_n = start_i;
      stop_n  = stop_i;
      cnt_n   = '0;
      armed_n = 1'b1;
      lt_n    = line_type_i;
    end else begin
      if (pos_q != POS_MAX) pos_n = pos_q + POS_W'(1);
      if (wr_en)            cnt_n = cnt_q + CNT_W'(1);
      if (close) begin
        armed_n = 1'b0;
        done_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      lt_q    <= 1'b0;
    end else begin
      pos_q   <= pos_n;
      start_q <= start_n;
      stop_q  <= stop_n;
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      done_q  <= done_n;
      lt_q    <= lt_n;
    end
  end

  assign wr_en_o     = wr_en;
  assign wr_addr_o   = cnt_q[WA_W-1:0];
  assign pos_o       = pos_q;
  assign count_o     = cnt_q;
  assign done_o      = done_q;
  assign line_type_o = lt_q;
  assign start_lsb_o = start_q[0];
endmodule

// File: rtl/linecap_ram.sv
module linecap_ram #(
  parameter int unsigned SMP_W = 9,
  parameter int unsigned DEPTH = 768,
  localparam int unsigned WA_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WA_W-1:0]  wa_i,
  input  logic [SMP_W-1:0] wd_i,
  input  logic [WA_W-1:0]  ra_i,
  output logic [SMP_W-1:0] rd_o
);
  logic [SMP_W-1:0] mem [DEPTH];
  logic [SMP_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem[ra_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/linecap_top.sv
module linecap_top
  import linecap_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF,
  parameter int unsigned POS_W = POS_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned WA_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             href_i,
  input  logic             line_type_i,
  input  logic             data_rise_i,
  input  logic             ref_rise_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] stop_i,
  input  logic [WA_W-1:0]  rd_addr_i,
  output logic [SMP_W-1:0] rd_data_o,
  output logic [1:0]       rd_colour_o,
  output logic             line_done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             rst_n_s;
  logic [SMP_W-1:0] smp_q;
  logic             ref_fall;
  logic             wr_en;
  logic [WA_W-1:0]  wr_addr;
  logic [POS_W-1:0] pos;
  logic             lt_q;
  logic             start_lsb;
  colour_e          col_n, col_q;

  linecap_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  linecap_front #(.SMP_W(SMP_W)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .data_rise_i(data_rise_i),
    .ref_rise_i (ref_rise_i),
    .smp_i      (smp_i),
    .href_i     (href_i),
    .smp_o      (smp_q),
    .ref_fall_o (ref_fall)
  );

  linecap_window #(.POS_W(POS_W), .DEPTH(DEPTH)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .ref_fall_i (ref_fall),
    .line_type_i(line_type_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .pos_o      (pos),
    .count_o    (count_o),
    .done_o     (line_done_o),
    .line_type_o(lt_q),
    .start_lsb_o(start_lsb)
  );

  linecap_ram #(.SMP_W(SMP_W), .DEPTH(DEPTH)) u_ram (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .we_i  (wr_en),
    .wa_i  (wr_addr),
    .wd_i  (smp_q),
    .ra_i  (rd_addr_i),
    .rd_o  (rd_data_o)
  );

  // Colour code: high bit selects the pair, low bit the member
  always_comb col_n = colour_e'({~lt_q, start_lsb ^ rd_addr_i[0]});

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) col_q <= COL_A;
    else          col_q <= col_n;
  end

  assign rd_colour_o = col_q;
endmodule

// File: rtl/linecap_chk.sv
module linecap_chk #(
  parameter int unsigned POS_W = 14,
  parameter int unsigned DEPTH = 768,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en,
  input logic             ref_fall,
  input logic [POS_W-1:0] pos,
  input logic [CNT_W-1:0] count,
  input logic             done
);
  // R3: a detected reference edge restarts position and count
  assert_ref_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_fall |=> (pos == '0) && (count == '0));

  // R5: every write moves the count (and hence the word) by one
  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> count == $past(count) + CNT_W'(1));

  // R6: no write once the line is full
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> count < CNT_W'(DEPTH));

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  // R7: nothing is written after the window closed
  assert_no_late_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !wr_en);
endmodule

bind linecap_top linecap_chk #(.POS_W(POS_W), .DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_n_s),
  .wr_en   (wr_en),
  .ref_fall(ref_fall),
  .pos     (pos),
  .count   (count_o),
  .done    (line_done_o)
);

// File: tb/linecap_top_bench.sv
`timescale 1ns/1ps
module linecap_top_bench;
  localparam int ARR = 1100;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [8:0] smp_i;
  logic       href_i, line_type_i, data_rise_i, ref_rise_i;
  logic [13:0] start_i, stop_i;
  logic [9:0] rd_addr_i;
  logic [8:0] rd_data_o;
  logic [1:0] rd_colour_o;
  logic       line_done_o;
  logic [9:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;
  int va [ARR];
  int vb [ARR];

  always #2 clk_i = ~clk_i;

  linecap_top u_linecap_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .href_i(href_i),
    .line_type_i(line_type_i), .data_rise_i(data_rise_i), .ref_rise_i(ref_rise_i),
    .start_i(start_i), .stop_i(stop_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_colour_o(rd_colour_o),
    .line_done_o(line_done_o), .count_o(count_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int even_stop(input int s);
    return s & ~1;
  endfunction

  function automatic int exp_count(input int s, input int p);
    int e = even_stop(p);
    if (s > e) return 0;
    if (e - s + 1 > 768) return 768;
    return e - s + 1;
  endfunction

  function automatic int close_pos(input int s, input int p);
    int e = even_stop(p);
    if (s <= e && s + 768 <= e) return s + 768;
    return e + 1;
  endfunction

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      href_i = 1'b1;
      smp_i  = 9'($urandom);
    end
  endtask

  task automatic run_line(input int s, input int p, input bit dr, input bit rr, input bit lt);
    int off, n_exp, len, dones, seen;
    @(posedge clk_i); #1;
    start_i = 14'(s); stop_i = 14'(p);
    data_rise_i = dr; ref_rise_i = rr; line_type_i = lt;
    idle_slots(6);
    off   = rr ? 2 : 1;                       // R3 latency
    n_exp = exp_count(s, p);
    len   = close_pos(s, p) + off + 6;
    dones = 0; seen = -1;
    for (int j = 0; j < len; j++) begin
      int a, b, q;
      a = int'(9'($urandom)); b = int'(9'($urandom));
      q = j - off;
      if (q >= 0 && q < ARR) begin va[q] = a; vb[q] = b; end
      @(posedge clk_i); #1;
      href_i = 1'b0; smp_i = 9'(a);
      #1;
      if (line_done_o) begin dones++; seen = int'(count_o); end
      #1;
      smp_i = 9'(b);
    end
    idle_slots(6);
    chk(dones == 1, "R7 done pulses", dones, 1);
    chk(seen == n_exp, (n_exp == 0) ? "R10 empty count" : "R4 R6 count", seen, n_exp);
    for (int w = 0; w < n_exp; w++) begin
      int ed, ec;
      ed = dr ? vb[s + w] : va[s + w];    // R2 edge choice
      ec = ((lt ? 0 : 1) << 1) | ((s + w) & 1);
      @(posedge clk_i); #1; rd_addr_i = 10'(w);
      @(posedge clk_i); #1;
      chk(int'(rd_data_o) == ed, "R2 R3 R5 R9 data", int'(rd_data_o), ed);
      chk(int'(rd_colour_o) == ec, "R8 colour", int'(rd_colour_o), ec);
    end
    chk(int'(count_o) == n_exp, "R7 count held", int'(count_o), n_exp);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; smp_i = '0; href_i = 1'b1; line_type_i = 1'b0;
    data_rise_i = 1'b1; ref_rise_i = 1'b1; start_i = '0; stop_i = '0; rd_addr_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(line_done_o == 1'b0, "R1 done in reset", int'(line_done_o), 0);
    chk(count_o == '0, "R1 count in reset", int'(count_o), 0);
    rst_ni = 1'b1;
    idle_slots(8);
    chk(line_done_o == 1'b0, "R1 done after reset", int'(line_done_o), 0);
    chk(count_o == '0, "R1 count after reset", int'(count_o), 0);

    run_line(0, 20, 1, 1, 1);
    run_line(3, 17, 0, 0, 0);     // odd stop -> last position 16
    run_line(4, 9, 1, 0, 1);
    run_line(5, 0, 0, 1, 0);      // R10
    run_line(6, 6, 1, 1, 0);      // single sample
    run_line(7, 7, 0, 1, 1);      // R10 via even-forced stop
    run_line(0, 1000, 1, 0, 0);   // R6 cap
    run_line(200, 1000, 0, 1, 1); // R6 cap at offset
    for (int k = 0; k < 20; k++)
      run_line(int'($urandom % 200), int'($urandom % 300),
               1'($urandom), 1'($urandom), 1'($urandom));

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule